// File: doc/BRIEF.md
# Single-Clock FIFO with Standard and Fall-Through Read Modes

This block is a first-in first-out buffer that runs on one clock. Its storage array has a power-of-two depth. The array size is fixed in bits, so the word width sets how deep the array is. One or two holding registers sit between the array and the read port, and these registers count as storage. As a result, the buffer holds more words than the array alone.

Two choices are made at elaboration time. The first is the read mode. In standard mode, a word appears on the data output after a read request. In fall-through mode, the oldest word is already on the output, and a read request acknowledges it. The second choice is an output register. It adds one cycle of latency: on read data in standard mode, and on the arrival of a new word at the output in fall-through mode. FULL and EMPTY are derived from registered state on the same clock, so each flag changes on an exact edge.

Top module: `sync_fifo_rm`

## Requirements
- R1: In standard mode the FIFO accepts exactly D+1 words before FULL rises, where D is the array depth. FULL falls right after the edge that accepts a read from a full FIFO.
- R2: In fall-through mode the FIFO accepts exactly D+2 words before FULL rises.
- R3: The array depth D is 2^(CAP_LOG2 - floor(log2(DATA_W))). With CAP_LOG2 = 6, a 4-bit width gives D = 16 and a 9-bit width gives D = 8.
- R4: In standard mode, `rd_data` takes the oldest word at the edge that accepts a read (`rd_en` high while `empty` is low). With the output register it takes that word one edge later, and in the meantime it shows the previously read word. Otherwise `rd_data` holds its value.
- R5: In fall-through mode, `rd_data` shows the oldest word whenever `empty` is low, with no read request. A read acknowledges that word, and `rd_data` holds while no read is accepted.
- R6: A write while `full` is high is dropped. Draining afterwards returns only the words that were accepted.
- R7: A read while `empty` is high is ignored. `empty` stays high, `rd_data` keeps its value, and a later write is read back intact.
- R8: After the first write into an empty FIFO, `empty` falls after the second edge (counting the write edge as the first) in standard mode, after the third in fall-through mode, and after the fourth in fall-through mode with the output register.
- R9: Synchronous active-high `rst` sets `empty`, clears `full` and discards all stored words.
- R10: `full` and `empty` are never high together.
- R11: Words leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request (standard) or acknowledge (fall-through) |
| rd_data | output | DATA_W | Read data |
| full | output | 1 | No free slot |
| empty | output | 1 | No readable word at the output stage |

## Verification
The bench runs all four combinations of mode and output register. The configurations use two widths, so the depth rule of R3 is exercised as well.

- **Capacity.** The bench fills each FIFO past its capacity and checks FULL on every write. A design that did not count a holding stage would go full one or two words early. A design that let a write through while full would return an extra word on drain.
- **Read timing.** The bench checks R4 on the cycle in between, where the output register must still show the previous word. A missing pipeline would show the new word too early.
- **Empty-flag timing.** The bench measures the edge at which EMPTY first falls. A design that exposed an unfilled fall-through stage would clear EMPTY too early and present stale data.
- **Empty reads and reset.** Reads on an empty FIFO, followed by a fresh write, expose any pointer that moved while it should not have. A reset with words still queued must leave nothing behind.

// File: rtl/fifo_rm_pkg.sv
package fifo_rm_pkg;

    typedef enum logic {
        RD_STD  = 1'b0,
        RD_FWFT = 1'b1
    } rd_mode_e;

    // Events that move the array pointers in one cycle
    typedef struct packed {
        logic wr_ok;   // accepted write into the array
        logic load;    // word leaves the array into a holding stage
    } fifo_ev_t;

    // Largest i with (v >> i) != 0
    function automatic int floor_log2(input int v);
        int r;
        r = 0;
        for (int i = 0; i < 31; i++) begin
            if ((v >> i) != 0) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/fifo_rm_mem.sv
module fifo_rm_mem #(
    parameter int DATA_W = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Captured by a holding stage on the next edge
    assign rdata = mem[raddr];

endmodule

// File: rtl/fifo_rm_ctrl.sv
module fifo_rm_ctrl
    import fifo_rm_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter bit FALL_LAG = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  fifo_ev_t          ev,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W-1:0] raddr,
    output logic              arr_full,
    output logic              arr_avail
);
    localparam int CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0] DEPTH_C = {1'b1, {ADDR_W{1'b0}}};

    logic [CNT_W-1:0] cnt;
    logic             lag;

    always_ff @(posedge clk) begin
        if (rst) begin
            waddr <= '0;
            raddr <= '0;
            cnt   <= '0;
        end else begin
            if (ev.wr_ok) waddr <= waddr + 1'b1;
            if (ev.load)  raddr <= raddr + 1'b1;
            case ({ev.wr_ok, ev.load})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Hide the word written last cycle from the read side for one extra cycle
    generate
        if (FALL_LAG) begin : g_lag
            always_ff @(posedge clk) begin
                if (rst) lag <= 1'b0;
                else     lag <= ev.wr_ok;
            end
        end else begin : g_nolag
            assign lag = 1'b0;
        end
    endgenerate

    assign arr_full  = (cnt == DEPTH_C);
    assign arr_avail = (cnt > {{ADDR_W{1'b0}}, lag});

endmodule

// File: rtl/fifo_rm_stages.sv
module fifo_rm_stages
    import fifo_rm_pkg::*;
#(
    parameter int       DATA_W    = 4,
    parameter rd_mode_e MODE      = RD_STD,
    parameter bit       DOUT_PIPE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              arr_avail,
    input  logic [DATA_W-1:0] mem_q,
    output logic              load,
    output logic              vis_valid,
    output logic              all_valid,
    output logic [DATA_W-1:0] dout
);
    logic take;
    assign take = rd_en && vis_valid;

    generate
        if (MODE == RD_FWFT) begin : g_fwft
            logic              s0_v, s1_v, adv;
            logic [DATA_W-1:0] s0_d, s1_d;

            assign adv  = s0_v && (!s1_v || take);
            assign load = arr_avail && (!s0_v || adv);

            always_ff @(posedge clk) begin
                if (rst) begin
                    s0_v <= 1'b0;
                    s1_v <= 1'b0;
                    s0_d <= '0;
                    s1_d <= '0;
                end else begin
                    if (adv)       s1_v <= 1'b1;
                    else if (take) s1_v <= 1'b0;
                    if (adv)       s1_d <= s0_d;
                    if (load) begin
                        s0_v <= 1'b1;
                        s0_d <= mem_q;
                    end else if (adv) begin
                        s0_v <= 1'b0;
                    end
                end
            end

            assign vis_valid = s1_v;
            assign all_valid = s0_v && s1_v;
            assign dout      = s1_d;
        end else begin : g_std
            logic              s_v;
            logic [DATA_W-1:0] s_d, q;

            assign load = arr_avail && (!s_v || take);

            always_ff @(posedge clk) begin
                if (rst) begin
                    s_v <= 1'b0;
                    s_d <= '0;
                    q   <= '0;
                end else begin
                    if (load)      s_v <= 1'b1;
                    else if (take) s_v <= 1'b0;
                    if (load) s_d <= mem_q;
                    if (take) q   <= s_d;
                end
            end

            assign vis_valid = s_v;
            assign all_valid = s_v;

            if (DOUT_PIPE) begin : g_pipe
                logic [DATA_W-1:0] q2;
                always_ff @(posedge clk) begin
                    if (rst) q2 <= '0;
                    else     q2 <= q;
                end
                assign dout = q2;
            end else begin : g_direct
                assign dout = q;
            end
        end
    endgenerate

endmodule

// File: rtl/sync_fifo_rm.sv
module sync_fifo_rm
    import fifo_rm_pkg::*;
#(
    parameter rd_mode_e MODE     = RD_STD,
    parameter bit       OUT_REG  = 1'b0,
    parameter int       DATA_W   = 4,
    parameter int       CAP_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty
);
    localparam int ADDR_W    = CAP_LOG2 - floor_log2(DATA_W);
    localparam bit DOUT_PIPE = (MODE == RD_STD)  && OUT_REG;
    localparam bit FALL_LAG  = (MODE == RD_FWFT) && OUT_REG;

    fifo_ev_t          ev;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [DATA_W-1:0] mem_q;
    logic              arr_full, arr_avail, load, vis_valid, all_valid;

    assign full     = arr_full && all_valid;
    assign empty    = !vis_valid;
    assign ev.wr_ok = wr_en && !full;
    assign ev.load  = load;

    fifo_rm_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (ev.wr_ok),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_q)
    );

    fifo_rm_ctrl #(.ADDR_W(ADDR_W), .FALL_LAG(FALL_LAG)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .waddr     (waddr),
        .raddr     (raddr),
        .arr_full  (arr_full),
        .arr_avail (arr_avail)
    );

    fifo_rm_stages #(.DATA_W(DATA_W), .MODE(MODE), .DOUT_PIPE(DOUT_PIPE)) u_stages (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .arr_avail (arr_avail),
        .mem_q     (mem_q),
        .load      (load),
        .vis_valid (vis_valid),
        .all_valid (all_valid),
        .dout      (rd_data)
    );

endmodule

// File: rtl/sync_fifo_rm_chk.sv
module sync_fifo_rm_chk
    import fifo_rm_pkg::*;
#(
    parameter rd_mode_e MODE    = RD_STD,
    parameter bit       OUT_REG = 1'b0,
    parameter int       DATA_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic              full,
    input logic              empty,
    input logic [DATA_W-1:0] rd_data
);
    AST_RESET_FLAGS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (empty && !full)); // R9

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(full && empty)); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> full); // R6

    generate
        if (MODE == RD_FWFT) begin : g_fwft_chk
            AST_HEAD_HELD: assert property (@(posedge clk) disable iff (rst)
                (!empty && !rd_en) |=> (!empty && $stable(rd_data))); // R5
        end else if (OUT_REG) begin : g_std_reg_chk
            AST_DOUT_HOLD_PIPE: assert property (@(posedge clk) disable iff (rst)
                !(rd_en && !empty) ##1 !(rd_en && !empty) |=> $stable(rd_data)); // R4
        end else begin : g_std_chk
            AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
                !(rd_en && !empty) |=> $stable(rd_data)); // R4
        end
    endgenerate

endmodule

bind sync_fifo_rm sync_fifo_rm_chk #(
    .MODE    (MODE),
    .OUT_REG (OUT_REG),
    .DATA_W  (DATA_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .full    (full),
    .empty   (empty),
    .rd_data (rd_data)
);

// File: tb/sync_fifo_rm_tb.sv
module sync_fifo_rm_tb;
    import fifo_rm_pkg::*;

    localparam int CAP_LOG2 = 6;
    localparam int NCFG     = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] din = '0;
    logic       wr [NCFG];
    logic       rd [NCFG];
    logic [8:0] dq [NCFG];
    logic       fl [NCFG];
    logic       em [NCFG];

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    // cfg g: bit1 = fall-through, bit0 = output register and 9-bit width
    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        localparam int W = (g % 2 == 1) ? 9 : 4;
        logic [W-1:0] q;
        sync_fifo_rm #(
            .MODE     ((g >= 2) ? RD_FWFT : RD_STD),
            .OUT_REG  (g % 2 == 1),
            .DATA_W   (W),
            .CAP_LOG2 (CAP_LOG2)
        ) u_dut (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr[g]),
            .wr_data (din[W-1:0]),
            .rd_en   (rd[g]),
            .rd_data (q),
            .full    (fl[g]),
            .empty   (em[g])
        );
        assign dq[g] = 9'(q);
    end

    function automatic bit is_fwft(input int k);  return k >= 2;      endfunction
    function automatic bit has_reg(input int k);  return k % 2 == 1;  endfunction
    function automatic logic [8:0] mask(input int k); return has_reg(k) ? 9'h1FF : 9'h00F; endfunction
    // R3: depth = 2^(CAP_LOG2 - floor(log2 W)); floor(log2 4)=2, floor(log2 9)=3
    function automatic int depth(input int k); return 1 << (CAP_LOG2 - (has_reg(k) ? 3 : 2)); endfunction
    function automatic int cap(input int k);   return depth(k) + (is_fwft(k) ? 2 : 1); endfunction
    function automatic int fill_lat(input int k);
        return !is_fwft(k) ? 2 : (has_reg(k) ? 4 : 3);
    endfunction

    task automatic chk(input bit ok, input string req, input int k, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cfg%0d actual=%0d expected=%0d", req, k, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        for (int i = 0; i < NCFG; i++) begin
            wr[i] = 1'b0;
            rd[i] = 1'b0;
        end
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic run_cfg(input int k);
        int  n;
        int  stored;
        bit  full_before;
        logic [8:0] exp_v;

        do_reset();
        chk(em[k] == 1'b1, "R9 empty after reset", k, int'(em[k]), 1);
        chk(fl[k] == 1'b0, "R9 full after reset", k, int'(fl[k]), 0);

        // R8: edge on which EMPTY first falls
        din   = 9'd1;
        wr[k] = 1'b1;
        tick();
        wr[k] = 1'b0;
        n = 1;
        while (em[k] && n < 12) begin
            tick();
            n++;
        end
        chk(n == fill_lat(k), "R8 empty fall edge", k, n, fill_lat(k));

        // R1 R2 R3 R6: fill past capacity
        stored = 1;
        for (int i = 2; i <= cap(k) + 3; i++) begin
            chk(fl[k] == (stored >= cap(k)), "R1 R2 full exact", k, int'(fl[k]), int'(stored >= cap(k)));
            chk(fl[k] && em[k] ? 1'b0 : 1'b1, "R10 flags exclusive", k, int'(em[k]), 0);
            full_before = fl[k];
            din   = 9'(i);
            wr[k] = 1'b1;
            tick();
            if (!full_before) stored++;
        end
        wr[k] = 1'b0;
        chk(stored == cap(k), "R3 capacity", k, stored, cap(k));
        chk(fl[k] == 1'b1, "R6 still full", k, int'(fl[k]), 1);

        // R4 R5 R11: drain
        for (int j = 1; j <= cap(k); j++) begin
            chk(em[k] == 1'b0, "R11 not empty while draining", k, int'(em[k]), 0);
            if (is_fwft(k)) begin
                exp_v = 9'(j) & mask(k);
                chk(dq[k] == exp_v, "R5 R11 head word", k, int'(dq[k]), int'(exp_v));
                rd[k] = 1'b1;
                tick();
                rd[k] = 1'b0;
            end else begin
                rd[k] = 1'b1;
                tick();
                rd[k] = 1'b0;
                if (has_reg(k)) begin
                    exp_v = 9'(j - 1) & mask(k);
                    chk(dq[k] == exp_v, "R4 pipe shows previous", k, int'(dq[k]), int'(exp_v));
                    tick();
                end
                exp_v = 9'(j) & mask(k);
                chk(dq[k] == exp_v, "R4 R11 read data", k, int'(dq[k]), int'(exp_v));
            end
            if (j == 1) chk(fl[k] == 1'b0, "R1 full falls after read", k, int'(fl[k]), 0);
        end
        chk(em[k] == 1'b1, "R6 no extra words", k, int'(em[k]), 1);
        chk(fl[k] == 1'b0, "R6 not full when drained", k, int'(fl[k]), 0);

        // R7: reads while empty
        exp_v = 9'(cap(k)) & mask(k);
        for (int r = 0; r < 3; r++) begin
            rd[k] = 1'b1;
            tick();
            rd[k] = 1'b0;
            chk(em[k] == 1'b1, "R7 stays empty", k, int'(em[k]), 1);
            chk(dq[k] == exp_v, "R7 data held", k, int'(dq[k]), int'(exp_v));
        end
        din   = 9'h0A5;
        wr[k] = 1'b1;
        tick();
        wr[k] = 1'b0;
        for (int t = 1; t < fill_lat(k); t++) tick();
        chk(em[k] == 1'b0, "R7 R8 word after empty reads", k, int'(em[k]), 0);
        exp_v = 9'h0A5 & mask(k);
        if (is_fwft(k)) begin
            chk(dq[k] == exp_v, "R7 R5 word intact", k, int'(dq[k]), int'(exp_v));
            rd[k] = 1'b1;
            tick();
            rd[k] = 1'b0;
        end else begin
            rd[k] = 1'b1;
            tick();
            rd[k] = 1'b0;
            if (has_reg(k)) tick();
            chk(dq[k] == exp_v, "R7 R4 word intact", k, int'(dq[k]), int'(exp_v));
        end
        chk(em[k] == 1'b1, "R7 empty again", k, int'(em[k]), 1);

        // R9: reset with queued words
        din   = 9'd3;
        wr[k] = 1'b1;
        tick();
        din   = 9'd4;
        tick();
        wr[k] = 1'b0;
        rst   = 1'b1;
        tick();
        rst   = 1'b0;
        for (int t = 0; t < 6; t++) begin
            chk(em[k] == 1'b1, "R9 words discarded", k, int'(em[k]), 1);
            chk(fl[k] == 1'b0, "R9 full clear", k, int'(fl[k]), 0);
            tick();
        end
    endtask

    initial begin
        for (int i = 0; i < NCFG; i++) begin
            wr[i] = 1'b0;
            rd[i] = 1'b0;
        end
        @(negedge clk);
        for (int k = 0; k < NCFG; k++) run_cfg(k);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule